// File: doc/BRIEF.md
# Byte-Granular Write Forwarding Unit

This block sits in front of a single-way row RAM whose rows are eight bytes wide. A row written in one cycle reaches the RAM's read port only two cycles later. The block covers that gap. It drives the RAM's per-byte write enables and write data from two sources. One is a partial store, which carries its own byte-select. The other is a full-row refill, which can be turned into a row of zeros. The RAM is modelled inside the block as an array with per-byte write enables and the same two-cycle write-to-read delay.

For every load, each output byte picks its own source, in this priority order:

1. the refill input, or zero when zeroing;
2. the store being written in this cycle;
3. a second-stage register that holds the previous cycle's write;
4. the RAM.

Because each byte chooses independently, two back-to-back partial stores to one row both reach a following load. The assembled word is registered.

All pins are plain per-cycle strobes. The block accepts a write and a load in every cycle and applies no back-pressure, so no ready signal exists on any side.

Top module: `rwf_forward_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, ld_valid and ld_rf_hit are 0 and ld_data is all zeros.
- R2: A store writes only the bytes whose st_bsel bit is set (bit i covers ld_data bits 8i+7..8i). A refill writes all eight bytes with rf_data, or with zeros when zero_en is 1. The result is readable from the RAM two or more cycles after the write.
- R3: A load whose ld_row equals wr_row in a cycle with st_en returns the store's bytes where st_bsel is set. Its other bytes come from older data.
- R4: A load one cycle after a write to the same row returns that write's bytes (the selected bytes for a store, all bytes for a refill) from the second stage.
- R5: For two stores in consecutive cycles to the same row, followed by a load in the second cycle or the next one, every byte returns the newest written value. The current store wins on overlapping bytes.
- R6: A load whose ld_row equals wr_row in a cycle with rf_ack returns the whole refill row (zeros when zero_en is 1) and raises ld_rf_hit with the data.
- R7: When ld_bypass is 1, every byte of the load returns rf_data, or zero when zero_en is 1, whatever the other sources hold.
- R8: ld_valid and ld_data appear one cycle after ld_en. ld_data holds its value in cycles without a load, even while writes go on.
- R9: A write to a row other than ld_row does not change the load result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_en | input | 1 | Store write this cycle |
| st_bsel | input | 8 | Store byte-select, one bit per byte |
| st_data | input | 64 | Store data |
| rf_ack | input | 1 | Refill row arrives this cycle |
| zero_en | input | 1 | Refill and bypass data are replaced by zeros |
| rf_data | input | 64 | Refill row data |
| wr_row | input | 4 | Row index written by a store or a refill |
| ld_en | input | 1 | Load request this cycle |
| ld_row | input | 4 | Row index read by the load |
| ld_bypass | input | 1 | Load completes from the refill input in full |
| ld_valid | output | 1 | Registered load strobe |
| ld_data | output | 64 | Registered assembled load data |
| ld_rf_hit | output | 1 | Load was served by a same-row refill |

## Verification
The assertions assume that a store and a refill never occur in the same cycle. The bench drives st_en and rf_ack as mutually exclusive strobes in every vector.

The assertions also assume that ld_en is low while reset is asserted, which the bench respects.

Load results are predicted from a shadow row array in the bench. This array is updated with the current cycle's write before each load, and the bench loads only rows it has first filled by refill, so RAM contents never matter before they are written.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SRC_REFILL = 2'b00,
    SRC_STORE  = 2'b01,
    SRC_STAGE2 = 2'b10,
    SRC_RAM    = 2'b11
  } byte_src_e;
endpackage

// File: rtl/rwf_wr_mux.sv
module rwf_wr_mux #(
  parameter int NB = 8,
  localparam int DW = NB * rwf_pkg::BYTE_W
) (
  input  logic          st_en,
  input  logic [NB-1:0] st_bsel,
  input  logic [DW-1:0] st_data,
  input  logic          rf_ack,
  input  logic          zero_en,
  input  logic [DW-1:0] rf_data,
  output logic          wr_act,
  output logic [DW-1:0] w_data,
  output logic [NB-1:0] w_sel,
  output logic [NB-1:0] ram_we
);
  always_comb begin
    if (st_en) begin
      w_data = st_data;
      w_sel  = st_bsel;
    end else begin
      w_data = zero_en ? '0 : rf_data;
      w_sel  = '1;
    end
  end

  assign wr_act = st_en | rf_ack;
  assign ram_we = wr_act ? w_sel : '0;
endmodule

// File: rtl/rwf_stage2.sv
module rwf_stage2 #(
  parameter int NB = 8,
  parameter int RW = 4,
  localparam int DW = NB * rwf_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_act,
  input  logic [DW-1:0] w_data,
  input  logic [NB-1:0] w_sel,
  input  logic [RW-1:0] wr_row,
  output logic          f_valid,
  output logic [DW-1:0] f_data,
  output logic [NB-1:0] f_sel,
  output logic [RW-1:0] f_row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_valid <= 1'b0;
      f_data  <= '0;
      f_sel   <= '0;
      f_row   <= '0;
    end else begin
      f_valid <= wr_act;
      f_data  <= w_data;
      f_sel   <= w_sel;
      f_row   <= wr_row;
    end
  end
endmodule

// File: rtl/rwf_ram.sv
module rwf_ram #(
  parameter int NB   = 8,
  parameter int ROWS = 16,
  localparam int RW = $clog2(ROWS),
  localparam int DW = NB * rwf_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int BW = rwf_pkg::BYTE_W;

  logic [NB-1:0] wp_we;
  logic [RW-1:0] wp_addr;
  logic [DW-1:0] wp_data;
  logic [DW-1:0] mem [ROWS];

  // Internal write stage: a write reaches the array one edge late,
  // giving a two-cycle write-to-read delay at the read port.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_we   <= '0;
      wp_addr <= '0;
      wp_data <= '0;
    end else begin
      wp_we   <= we;
      wp_addr <= waddr;
      wp_data <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (wp_we[b]) mem[wp_addr][b*BW +: BW] <= wp_data[b*BW +: BW];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rwf_byte_mux.sv
module rwf_byte_mux #(
  parameter int NB = 8,
  localparam int DW = NB * rwf_pkg::BYTE_W
) (
  input  logic          force_all,
  input  logic          zero_en,
  input  logic [DW-1:0] rf_data,
  input  logic          s1_hit,
  input  logic [NB-1:0] st_bsel,
  input  logic [DW-1:0] st_data,
  input  logic          s2_hit,
  input  logic [NB-1:0] f_sel,
  input  logic [DW-1:0] f_data,
  input  logic [DW-1:0] ram_data,
  output logic [DW-1:0] mux_out
);
  import rwf_pkg::*;
  localparam int BW = BYTE_W;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    byte_src_e      src;
    logic [BW-1:0]  byte_q;

    always_comb begin
      if (force_all)                 src = SRC_REFILL;
      else if (s1_hit && st_bsel[b]) src = SRC_STORE;
      else if (s2_hit && f_sel[b])   src = SRC_STAGE2;
      else                           src = SRC_RAM;

      case (src)
        SRC_REFILL: byte_q = zero_en ? '0 : rf_data[b*BW +: BW];
        SRC_STORE:  byte_q = st_data[b*BW +: BW];
        SRC_STAGE2: byte_q = f_data[b*BW +: BW];
        default:    byte_q = ram_data[b*BW +: BW];
      endcase
    end

    assign mux_out[b*BW +: BW] = byte_q;
  end
endmodule

// File: rtl/rwf_forward_unit.sv
module rwf_forward_unit #(
  parameter int NB   = 8,
  parameter int ROWS = 16,
  localparam int RW = $clog2(ROWS),
  localparam int DW = NB * rwf_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_en,
  input  logic [NB-1:0] st_bsel,
  input  logic [DW-1:0] st_data,
  input  logic          rf_ack,
  input  logic          zero_en,
  input  logic [DW-1:0] rf_data,
  input  logic [RW-1:0] wr_row,
  input  logic          ld_en,
  input  logic [RW-1:0] ld_row,
  input  logic          ld_bypass,
  output logic          ld_valid,
  output logic [DW-1:0] ld_data,
  output logic          ld_rf_hit
);
  logic          wr_act;
  logic [DW-1:0] w_data;
  logic [NB-1:0] w_sel;
  logic [NB-1:0] ram_we;
  logic          f_valid;
  logic [DW-1:0] f_data;
  logic [NB-1:0] f_sel;
  logic [RW-1:0] f_row;
  logic [DW-1:0] ram_q;
  logic [DW-1:0] mux_out;
  logic          same_row;
  logic          s1_hit;
  logic          rl_hit;
  logic          s2_hit;
  logic          force_all;

  rwf_wr_mux #(.NB(NB)) u_wr_mux (
    .st_en(st_en), .st_bsel(st_bsel), .st_data(st_data),
    .rf_ack(rf_ack), .zero_en(zero_en), .rf_data(rf_data),
    .wr_act(wr_act), .w_data(w_data), .w_sel(w_sel), .ram_we(ram_we)
  );

  rwf_ram #(.NB(NB), .ROWS(ROWS)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(wr_row),
    .wdata(w_data), .raddr(ld_row), .rdata(ram_q)
  );

  rwf_stage2 #(.NB(NB), .RW(RW)) u_stage2 (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .w_data(w_data),
    .w_sel(w_sel), .wr_row(wr_row), .f_valid(f_valid),
    .f_data(f_data), .f_sel(f_sel), .f_row(f_row)
  );

  assign same_row  = (ld_row == wr_row);
  assign s1_hit    = st_en & same_row;
  assign rl_hit    = rf_ack & same_row;
  assign s2_hit    = f_valid & (ld_row == f_row);
  assign force_all = ld_bypass | rl_hit;

  rwf_byte_mux #(.NB(NB)) u_byte_mux (
    .force_all(force_all), .zero_en(zero_en), .rf_data(rf_data),
    .s1_hit(s1_hit), .st_bsel(st_bsel), .st_data(st_data),
    .s2_hit(s2_hit), .f_sel(f_sel), .f_data(f_data),
    .ram_data(ram_q), .mux_out(mux_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid  <= 1'b0;
      ld_data   <= '0;
      ld_rf_hit <= 1'b0;
    end else begin
      ld_valid  <= ld_en;
      ld_rf_hit <= ld_en & rl_hit;
      if (ld_en) ld_data <= mux_out;
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_en && rf_ack)); // R2
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_ack && zero_en) |-> (w_data == '0)); // R2
  AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we != '0) |-> (st_en || rf_ack)); // R2
  AST_FORCE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    force_all |-> (mux_out == (zero_en ? '0 : rf_data))); // R7
  AST_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rf_hit |-> ld_valid); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_en) |-> $stable(ld_data)); // R8
endmodule

// File: tb/test_rwf_forward_unit.sv
module test_rwf_forward_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_en = 1'b0;
  logic [7:0]  st_bsel = '0;
  logic [63:0] st_data = '0;
  logic        rf_ack = 1'b0;
  logic        zero_en = 1'b0;
  logic [63:0] rf_data = '0;
  logic [3:0]  wr_row = '0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_row = '0;
  logic        ld_bypass = 1'b0;
  logic        ld_valid;
  logic [63:0] ld_data;
  logic        ld_rf_hit;

  int total = 0;
  int bad = 0;
  logic [63:0] shadow [16];

  always #2 clk = ~clk;

  rwf_forward_unit i_rwf_forward_unit (
    .clk(clk), .rst_n(rst_n), .st_en(st_en), .st_bsel(st_bsel),
    .st_data(st_data), .rf_ack(rf_ack), .zero_en(zero_en),
    .rf_data(rf_data), .wr_row(wr_row), .ld_en(ld_en), .ld_row(ld_row),
    .ld_bypass(ld_bypass), .ld_valid(ld_valid), .ld_data(ld_data),
    .ld_rf_hit(ld_rf_hit)
  );

  typedef struct packed {
    logic        st;
    logic [7:0]  bs;
    logic        rf;
    logic        zr;
    logic        bp;
    logic [3:0]  wr;
    logic        ld;
    logic [3:0]  lr;
    logic [63:0] dat;
    logic [3:0]  tg;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 64'hA0A1A2A3A4A5A6A7, 4'd2},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd1, 1'b0, 4'd0, 64'hB0B1B2B3B4B5B6B7, 4'd2},
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd2, 1'b0, 4'd0, 64'hC0C1C2C3C4C5C6C7, 4'd2},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3, 1'b1, 4'd0, 64'hD0D1D2D3D4D5D6D7, 4'd2},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd3, 64'h0, 4'd4},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd2, 64'h0, 4'd2},
    '{1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, 4'd1, 1'b1, 4'd1, 64'h1111111111111111, 4'd3},
    '{1'b1, 8'hF0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b1, 4'd1, 64'h2222222222222222, 4'd5},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd1, 64'h0, 4'd5},
    '{1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd0, 64'h3333333333333333, 4'd3},
    '{1'b1, 8'h0C, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd0, 64'h4444444444444444, 4'd5},
    '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 4'd2, 1'b1, 4'd3, 64'h5555555555555555, 4'd9},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3, 1'b1, 4'd3, 64'h6677889900AABBCC, 4'd6},
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd0, 1'b1, 4'd0, 64'hFFFFFFFFFFFFFFFF, 4'd6},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1, 4'd1, 64'h0123456789ABCDEF, 4'd7},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 4'd0, 1'b1, 4'd2, 64'hFEDCBA9876543210, 4'd7},
    '{1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 4'd1, 64'h7777777777777777, 4'd9}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    st_en = 1'b0; rf_ack = 1'b0; zero_en = 1'b0; ld_en = 1'b0; ld_bypass = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t v;
    logic [63:0] exp_d;
    logic [63:0] keep;
    for (int r = 0; r < 16; r++) shadow[r] = '0;

    // R1: reset state, during and just after reset
    repeat (3) @(negedge clk);
    chk("R1", {63'd0, ld_valid}, 64'd0);
    chk("R1", ld_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {62'd0, ld_valid, ld_rf_hit}, 64'd0);

    // Vector walk with a shadow row model
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      st_en = v.st; st_bsel = v.bs; st_data = v.dat;
      rf_ack = v.rf; zero_en = v.zr; rf_data = v.dat;
      wr_row = v.wr; ld_en = v.ld; ld_row = v.lr; ld_bypass = v.bp;
      if (v.st) begin
        for (int b = 0; b < 8; b++)
          if (v.bs[b]) shadow[v.wr][b*8 +: 8] = v.dat[b*8 +: 8];
      end else if (v.rf) begin
        shadow[v.wr] = v.zr ? 64'd0 : v.dat;
      end
      exp_d = v.bp ? (v.zr ? 64'd0 : v.dat) : shadow[v.lr];
      @(posedge clk);
      @(negedge clk);
      if (v.ld) begin
        chk(tag_name(v.tg), ld_data, exp_d);
        chk("R6", {63'd0, ld_rf_hit}, {63'd0, (v.rf && (v.wr == v.lr))});
        chk("R8", {63'd0, ld_valid}, 64'd1);
      end
    end

    // R8: data holds without a load while writes continue to the loaded row
    idle();
    keep = ld_data;
    st_en = 1'b1; st_bsel = 8'hFF; st_data = 64'h9999999999999999; wr_row = 4'd1;
    shadow[1] = 64'h9999999999999999;
    @(posedge clk); @(negedge clk);
    st_en = 1'b0;
    chk("R8", {63'd0, ld_valid}, 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R8", ld_data, keep);

    // R8: one-cycle latency of a new load
    ld_en = 1'b1; ld_row = 4'd1;
    #1;
    chk("R8", {63'd0, ld_valid}, 64'd0);
    @(posedge clk); @(negedge clk);
    ld_en = 1'b0;
    chk("R8", ld_data, shadow[1]);
    chk("R8", {63'd0, ld_valid}, 64'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule